// File: doc/BRIEF.md
# Comparator control and interrupt logic

This block is the digital side of an analog voltage comparator. The comparator's raw decision arrives asynchronously. The block passes it through a flip-flop synchronizer and exposes the result as a read-only bit of an 8-bit control/status register. A software bus reaches that register through a single address, using a write enable, write data and combinational read data.

Edges on the synchronized result set an interrupt flag. The edge mode register field chooses which edges count. An interrupt request is raised when the flag, the local enable and a global interrupt enable are all high. The flag is cleared in either of two ways: when the CPU acknowledges the interrupt vector, or when software writes a one to the flag bit.

The block also drives several lines that leave it:
- a power-down line to the comparator;
- the select for the positive input: external pin or internal reference;
- the select for the negative input: external pin or one of eight ADC channels;
- a trigger line toward a timer's capture input, which can be gated on or off.

Top module: `cmp_wrap`

## Requirements
- R1: After reset every writable register bit is 0, so `reg_rdata` reads 8'h00 while `cmp_raw` has been low. All outputs are inactive.
- R2: A write stores `reg_wdata` bits 7, 6, 3, 2, 1 and 0 into the register fields power-off, reference-select, interrupt-enable, capture-enable and mode[1:0]. Bit 5 is read-only, and a write to it has no effect.
- R3: `pwr_down` equals register bit 7. `pos_sel_ref` equals register bit 6, where 1 selects the internal reference and 0 the external positive pin.
- R4: Register bit 5 is `cmp_raw` after a two-flop synchronizer. A level present at a clock edge first reads back after the following edge.
- R5: The flag (bit 4) sets one cycle after bit 5 changes, when the change matches the mode in bits 1:0. The mode codes are: 00 any change, 10 falling only, 11 rising only, 01 never.
- R6: While bit 7 is 1, changes of bit 5 never set the flag.
- R7: The flag clears on `irq_ack` or on a write with `reg_wdata[4]`=1. A write with bit 4 at 0 leaves the flag unchanged. A set event in the same cycle as a clear leaves the flag at 1.
- R8: `irq` is 1 exactly when the flag, register bit 3 and `gie` are all 1.
- R9: `cap_trig` follows register bit 5 when register bit 2 is 1. It is held at 0 when bit 2 is 0.
- R10: `neg_sel_adc` is 1 and `neg_chan` equals `chan_sel[2:0]` when `mux_en`=1, `adc_on`=0 and `chan_sel[4:3]`=00. For example, codes 00100 to 00111 give channels 4 to 7. In every other case `neg_sel_adc`=0 and `neg_chan`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_raw | input | 1 | Raw comparator decision, asynchronous |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_ack | input | 1 | Interrupt vector acknowledge |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| pwr_down | output | 1 | Comparator power-down |
| pos_sel_ref | output | 1 | Positive input select: 1 internal reference, 0 pin |
| mux_en | input | 1 | Negative input multiplexing allowed |
| adc_on | input | 1 | ADC is enabled (blocks the negative mux) |
| chan_sel | input | 5 | Channel select code |
| neg_sel_adc | output | 1 | Negative input taken from an ADC channel |
| neg_chan | output | 3 | Selected ADC channel |
| cap_trig | output | 1 | Trigger toward the timer capture input |

## Verification
Several properties are checked on every cycle:
- the request gating;
- the gating of the capture trigger and of the negative mux select;
- the two-cycle synchronizer lag;
- that a flag rise needs a change of the output bit with power-off low in that cycle;
- that a flag fall needs an acknowledge or a one written to the flag.

Only the bench's scenarios can show that each edge mode picks the right direction and that reserved mode 01 sets nothing. The same holds for a written zero leaving the flag alone, for set winning over a clear in the same cycle, and for the write mask of the read-only bit.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

   typedef enum logic [1:0] {
      MODE_ANY  = 2'b00,
      MODE_NONE = 2'b01,
      MODE_FALL = 2'b10,
      MODE_RISE = 2'b11
   } edge_mode_e;

   localparam int REG_W = 8;
   localparam int B_OFF = 7;
   localparam int B_REF = 6;
   localparam int B_OUT = 5;
   localparam int B_FLG = 4;
   localparam int B_IE  = 3;
   localparam int B_CAP = 2;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("cmp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_i};
   end

   assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/cmp_edge.sv
module cmp_edge
   import cmp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       samp,
   input  logic       off,
   input  edge_mode_e mode,
   output logic       hit
);

   logic prev;
   logic rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= samp;
   end

   assign rise = samp & ~prev;
   assign fall = ~samp & prev;

   always_comb begin
      unique case (mode)
         MODE_ANY:  hit = rise | fall;
         MODE_FALL: hit = fall;
         MODE_RISE: hit = rise;
         default:   hit = 1'b0;
      endcase
      if (off) hit = 1'b0;
   end

endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
   import cmp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   input  logic             hit,
   input  logic             ack,
   input  logic             out_bit,
   output logic [REG_W-1:0] rdata,
   output logic             off,
   output logic             refsel,
   output logic             ie,
   output logic             cap,
   output edge_mode_e       mode,
   output logic             flag
);

   logic unused_wbit;
   logic sw_clr;

   assign unused_wbit = wdata[B_OUT];
   assign sw_clr      = we & wdata[B_FLG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off    <= 1'b0;
         refsel <= 1'b0;
         ie     <= 1'b0;
         cap    <= 1'b0;
         mode   <= MODE_ANY;
      end else if (we) begin
         off    <= wdata[B_OFF];
         refsel <= wdata[B_REF];
         ie     <= wdata[B_IE];
         cap    <= wdata[B_CAP];
         mode   <= edge_mode_e'(wdata[1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flag <= 1'b0;
      else if (hit)            flag <= 1'b1;
      else if (ack || sw_clr)  flag <= 1'b0;
   end

   always_comb begin
      rdata        = '0;
      rdata[B_OFF] = off;
      rdata[B_REF] = refsel;
      rdata[B_OUT] = out_bit;
      rdata[B_FLG] = flag;
      rdata[B_IE]  = ie;
      rdata[B_CAP] = cap;
      rdata[1:0]   = mode;
   end

endmodule

// File: rtl/cmp_wrap.sv
module cmp_wrap
   import cmp_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = 5,
   parameter int CHAN_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_raw,
   input  logic              reg_we,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              irq_ack,
   input  logic              gie,
   output logic              irq,
   output logic              pwr_down,
   output logic              pos_sel_ref,
   input  logic              mux_en,
   input  logic              adc_on,
   input  logic [SEL_W-1:0]  chan_sel,
   output logic              neg_sel_adc,
   output logic [CHAN_W-1:0] neg_chan,
   output logic              cap_trig
);

   logic       samp, hit, off, refsel, ie, cap, flag;
   edge_mode_e mode;
   logic       mux_ok;

   cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(cmp_raw), .sync_o(samp)
   );

   cmp_edge u_edge (
      .clk(clk), .rst_n(rst_n), .samp(samp), .off(off), .mode(mode), .hit(hit)
   );

   cmp_regs u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .hit(hit),
      .ack(irq_ack), .out_bit(samp), .rdata(reg_rdata), .off(off),
      .refsel(refsel), .ie(ie), .cap(cap), .mode(mode), .flag(flag)
   );

   assign irq         = flag & ie & gie;
   assign pwr_down    = off;
   assign pos_sel_ref = refsel;
   assign cap_trig    = cap & samp;

   generate
      if (SEL_W < CHAN_W) begin : g_bad
         $error("cmp_wrap: SEL_W must not be narrower than CHAN_W");
      end else if (SEL_W > CHAN_W) begin : g_wide
         assign mux_ok = mux_en & ~adc_on & ~|chan_sel[SEL_W-1:CHAN_W];
      end else begin : g_exact
         assign mux_ok = mux_en & ~adc_on;
      end
   endgenerate

   assign neg_sel_adc = mux_ok;
   assign neg_chan    = mux_ok ? chan_sel[CHAN_W-1:0] : '0;

endmodule

// File: rtl/cmp_wrap_chk.sv
module cmp_wrap_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmp_raw,
   input logic       reg_we,
   input logic [7:0] reg_wdata,
   input logic [7:0] reg_rdata,
   input logic       irq_ack,
   input logic       gie,
   input logic       irq,
   input logic       mux_en,
   input logic       adc_on,
   input logic       neg_sel_adc,
   input logic       cap_trig
);

   logic unused_wdata;
   assign unused_wdata = ^{reg_wdata[7:5], reg_wdata[3:0]};

   // R8
   a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (reg_rdata[4] & reg_rdata[3] & gie));

   // R5
   a_r5_flag_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[4]) |-> ($past(reg_rdata[5]) != $past(reg_rdata[5], 2)));

   // R6
   a_r6_off_blocks_set: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[4]) |-> !$past(reg_rdata[7]));

   // R7
   a_r7_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_rdata[4]) |-> $past(irq_ack || (reg_we && reg_wdata[4])));

   // R9
   a_r9_cap_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[2] |-> !cap_trig);

   // R10
   a_r10_neg_gate: assert property (@(posedge clk) disable iff (!rst_n)
      neg_sel_adc |-> (mux_en && !adc_on));

   generate
      if (SYNC_STAGES == 2) begin : g_lag
         // R4
         a_r4_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2)) |-> (reg_rdata[5] == $past(cmp_raw, 2)));
      end
   endgenerate

endmodule

bind cmp_wrap cmp_wrap_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/tb_cmp_wrap.sv
module tb_cmp_wrap;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_raw = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq_ack = 1'b0;
   logic       gie = 1'b0;
   logic       irq, pwr_down, pos_sel_ref;
   logic       mux_en = 1'b0;
   logic       adc_on = 1'b0;
   logic [4:0] chan_sel = 5'd0;
   logic       neg_sel_adc;
   logic [2:0] neg_chan;
   logic       cap_trig;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 0;

   always #4 clk = ~clk;

   cmp_wrap dut (
      .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
      .gie(gie), .irq(irq), .pwr_down(pwr_down), .pos_sel_ref(pos_sel_ref),
      .mux_en(mux_en), .adc_on(adc_on), .chan_sel(chan_sel),
      .neg_sel_adc(neg_sel_adc), .neg_chan(neg_chan), .cap_trig(cap_trig)
   );

   // behavioural reference model
   logic       m_s1, m_s2, m_prev, m_flag;
   logic [7:0] m_ctl;

   always @(posedge clk) begin
      logic ev;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_flag = 0; m_ctl = 0;
      end else begin
         ev = 0;
         if (!m_ctl[7] && (m_s2 != m_prev)) begin
            case (m_ctl[1:0])
               2'b00: ev = 1;
               2'b10: ev = (m_s2 == 0);
               2'b11: ev = (m_s2 == 1);
               default: ev = 0;
            endcase
         end
         if (ev) m_flag = 1;
         else if (irq_ack || (reg_we && reg_wdata[4])) m_flag = 0;
         if (reg_we) m_ctl = reg_wdata & 8'hCF;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = cmp_raw;
      end
   end

   function automatic logic [7:0] exp_rdata();
      return m_ctl | {2'b00, m_s2, m_flag, 4'b0000};
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      logic sel_e;
      #2;
      if (rst_n && !done) begin
         sel_e = mux_en && !adc_on && (chan_sel < 5'd8);
         chk("R2 R5 R7 rdata", reg_rdata, exp_rdata());
         chk("R8 irq", {7'd0, irq}, {7'd0, m_flag & m_ctl[3] & gie});
         chk("R3 pwr_down", {7'd0, pwr_down}, {7'd0, m_ctl[7]});
         chk("R3 pos_sel_ref", {7'd0, pos_sel_ref}, {7'd0, m_ctl[6]});
         chk("R9 cap_trig", {7'd0, cap_trig}, {7'd0, m_ctl[2] & m_s2});
         chk("R10 neg", {4'd0, neg_sel_adc, neg_chan},
             {4'd0, sel_e, sel_e ? chan_sel[2:0] : 3'd0});
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
      #3;
   endtask

   task automatic wr(logic [7:0] v);
      reg_we = 1; reg_wdata = v;
      tick(1);
      reg_we = 0; reg_wdata = 8'h00;
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      tick(3);
      rst_n = 1;
      tick(1);
      chk("R1 reset rdata", reg_rdata, 8'h00);
      chk("R1 reset outputs", {4'd0, irq, pwr_down, pos_sel_ref, cap_trig}, 8'h00);

      wr(8'hFF);
      chk("R2 write mask", reg_rdata, 8'hCF);
      chk("R3 pwr and ref", {6'd0, pwr_down, pos_sel_ref}, 8'h03);
      wr(8'h00);

      // R4 lag
      cmp_raw = 1;
      tick(1);
      chk("R4 one edge still old", {7'd0, reg_rdata[5]}, 8'h00);
      tick(1);
      chk("R4 two edges new", {7'd0, reg_rdata[5]}, 8'h01);
      cmp_raw = 0; tick(4);

      // R5 rising mode, R8 request
      wr(8'h0B); gie = 1;
      cmp_raw = 1; tick(3);
      chk("R5 rise sets flag", {7'd0, reg_rdata[4]}, 8'h01);
      chk("R8 irq asserted", {7'd0, irq}, 8'h01);
      gie = 0; tick(1);
      chk("R8 gie gates irq", {7'd0, irq}, 8'h00);
      gie = 1;
      irq_ack = 1; tick(1); irq_ack = 0;
      chk("R7 ack clears", {7'd0, reg_rdata[4]}, 8'h00);
      cmp_raw = 0; tick(4);
      chk("R5 fall ignored in rise mode", {7'd0, reg_rdata[4]}, 8'h00);

      // falling mode
      wr(8'h0A);
      cmp_raw = 1; tick(4);
      chk("R5 rise ignored in fall mode", {7'd0, reg_rdata[4]}, 8'h00);
      cmp_raw = 0; tick(3);
      chk("R5 fall sets flag", {7'd0, reg_rdata[4]}, 8'h01);
      wr(8'h0A);
      chk("R7 write zero keeps flag", {7'd0, reg_rdata[4]}, 8'h01);
      wr(8'h1A);
      chk("R7 write one clears", {7'd0, reg_rdata[4]}, 8'h00);

      // reserved mode
      wr(8'h09);
      cmp_raw = 1; tick(4); cmp_raw = 0; tick(4);
      chk("R5 reserved mode sets nothing", {7'd0, reg_rdata[4]}, 8'h00);

      // toggle mode with power-off
      wr(8'h88);
      cmp_raw = 1; tick(4); cmp_raw = 0; tick(4);
      chk("R6 off blocks flag", {7'd0, reg_rdata[4]}, 8'h00);

      // toggle mode, set and clear in same cycle
      wr(8'h08);
      cmp_raw = 1; tick(2);
      wr(8'h18);
      chk("R7 set beats clear", {7'd0, reg_rdata[4]}, 8'h01);
      wr(8'h18);
      cmp_raw = 0; tick(3);
      chk("R5 toggle on fall", {7'd0, reg_rdata[4]}, 8'h01);
      wr(8'h18);

      // capture routing
      wr(8'h04);
      cmp_raw = 1; tick(3);
      chk("R9 cap follows output", {7'd0, cap_trig}, 8'h01);
      wr(8'h00);
      chk("R9 cap held low", {7'd0, cap_trig}, 8'h00);
      cmp_raw = 0; tick(3);

      // negative mux
      mux_en = 1; chan_sel = 5'b00110; tick(1);
      chk("R10 channel six", {4'd0, neg_sel_adc, neg_chan}, 8'h0E);
      chan_sel = 5'b00111; tick(1);
      chk("R10 channel seven", {4'd0, neg_sel_adc, neg_chan}, 8'h0F);
      adc_on = 1; tick(1);
      chk("R10 adc on blocks", {4'd0, neg_sel_adc, neg_chan}, 8'h00);
      adc_on = 0; chan_sel = 5'b01100; tick(1);
      chk("R10 out of range code", {4'd0, neg_sel_adc, neg_chan}, 8'h00);
      mux_en = 0; chan_sel = 5'b00100; tick(1);
      chk("R10 mux disabled", {4'd0, neg_sel_adc, neg_chan}, 8'h00);

      tick(2);
      finish_run();
   end

endmodule